// File: doc/BRIEF.md
# Per-Bit Configurable GPIO Port

An eight-bit general-purpose I/O port whose pins are each set up on their own. Three registers control the port: a data register, a direction register and an option register. For each pin, the three bits at the same position select one of six modes. The block turns that choice into pad controls: output enable, output level, pull-up enable, and a one-hot analog-select vector that goes to an off-block converter. Pad electronics and the converter itself are not part of this block.

When a pin is an input, its data bit does not set a level. It picks between two input flavours instead: with or without pull-up, or interrupt versus analog. A read of the data register returns a per-bit mix. A bit set to output returns its latched value, and a bit set to input returns its synchronized pin level. Interrupt-mode pins are ANDed onto one active-low interrupt line. A fault flag rises when more than one pin decodes to analog mode, because the analog switches would then short those pins together.

Software reaches the registers through a small bus: a 2-bit address, a write strobe and write data, with combinational read data. The pin controls, the interrupt line and the fault flag come from registers.

Top module: `gpio_port`

## Requirements
- R1: A synchronous reset clears the data, direction and option registers. One cycle later every pin is an undriven input with pull-up: pin_pu = 8'hFF, pin_oe = 0, pin_out = 0, ana_sel = 0, irq_n = 1, ana_conflict = 0.
- R2: With direction bit 0 and option bit 0, the pin is not driven. Its pull-up is on when the data bit is 0 and off when it is 1.
- R3: With direction 0 and option 1, a data bit of 0 gives an interrupt input with pull-up and no drive. A data bit of 1 gives an analog input: the ana_sel bit is 1, with no pull-up and no drive.
- R4: With direction 1 and option 0 (open-drain), pin_out is 0 and pin_oe is the inverse of the data bit. The pull-up is off.
- R5: With direction 1 and option 1 (push-pull), pin_oe is 1 and pin_out equals the data bit. The pull-up is off. pin_out is never 1 while pin_oe is 0.
- R6: Reading address 0 returns, per bit, the data register bit when direction is 1. When direction is 0 it returns pin_in after a two-flop synchronizer, so a pin change shows on the second rising edge after it.
- R7: Address 1 (direction) and address 2 (option) read back exactly the last value written. Address 3 reads as zero, and writes to it change nothing.
- R8: A write to address 0 stores the data bits whatever the direction setting, and bits of input pins then change that pin's mode.
- R9: irq_n is the AND of the synchronized levels of all interrupt-mode pins. Pins in any other mode count as 1.
- R10: ana_conflict is 1 exactly when two or more bits of ana_sel are 1.
- R11: pin_oe, pin_out, pin_pu, ana_sel, irq_n and ana_conflict change on the clock edge after the register write or synchronized pin change that causes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register select: 0 data, 1 direction, 2 option, 3 unused |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for addr |
| pin_in | input | 8 | Asynchronous pad input levels |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin driven level |
| pin_pu | output | 8 | Per-pin pull-up enable |
| ana_sel | output | 8 | Analog channel select |
| irq_n | output | 1 | Combined active-low interrupt |
| ana_conflict | output | 1 | More than one analog pin selected |

## Verification
The assertions check on every cycle that the analog select never comes with a pull-up or a drive, and that the output level is never 1 on an undriven pin. They also check that the conflict flag agrees with the number of set analog-select bits, and that direction writes read back on the next cycle. Only the bench scenarios can show the mode each bit combination produces, the two-edge latency of the synchronizer on reads and on the interrupt, and the mix of latched and live bits in a data read. The same holds for the way a data write re-selects input modes, and for writes to the unused address being dropped.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [2:0] {
    MODE_IN_PU   = 3'd0,
    MODE_IN_FLT  = 3'd1,
    MODE_IRQ_PU  = 3'd2,
    MODE_ANALOG  = 3'd3,
    MODE_OPEN_DR = 3'd4,
    MODE_PUSH_PL = 3'd5
  } pin_mode_e;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_DIR  = 2'd1;
  localparam logic [1:0] ADDR_OPT  = 2'd2;

  function automatic pin_mode_e decode_mode(input logic dir, input logic opt, input logic dat);
    if (dir) return opt ? MODE_PUSH_PL : MODE_OPEN_DR;
    case ({opt, dat})
      2'b00:   return MODE_IN_PU;
      2'b01:   return MODE_IN_FLT;
      2'b10:   return MODE_IRQ_PU;
      default: return MODE_ANALOG;
    endcase
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= async_in;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   addr,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] dat_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] opt_q
);
  import gpio_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      dat_q <= '0;
      dir_q <= '0;
      opt_q <= '0;
    end else if (wr_en) begin
      case (addr)
        ADDR_DATA: dat_q <= wr_data;
        ADDR_DIR:  dir_q <= wr_data;
        ADDR_OPT:  opt_q <= wr_data;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      ADDR_DATA: rd_data = (dir_q & dat_q) | (~dir_q & pin_sync);
      ADDR_DIR:  rd_data = dir_q;
      ADDR_OPT:  rd_data = opt_q;
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bit_cell.sv
module gpio_bit_cell (
  input  logic dir,
  input  logic opt,
  input  logic dat,
  input  logic lvl,
  output logic oe,
  output logic drv,
  output logic pu,
  output logic ana,
  output logic irq_term
);
  import gpio_pkg::*;
  pin_mode_e mode;

  always_comb begin
    mode     = decode_mode(dir, opt, dat);
    oe       = 1'b0;
    drv      = 1'b0;
    pu       = 1'b0;
    ana      = 1'b0;
    irq_term = 1'b1;
    case (mode)
      MODE_IN_PU:   pu = 1'b1;
      MODE_IRQ_PU: begin
        pu       = 1'b1;
        irq_term = lvl;
      end
      MODE_ANALOG:  ana = 1'b1;
      MODE_OPEN_DR: oe = ~dat;
      MODE_PUSH_PL: begin
        oe  = 1'b1;
        drv = dat;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   addr,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_pu,
  output logic [W-1:0] ana_sel,
  output logic         irq_n,
  output logic         ana_conflict
);
  logic [W-1:0] pin_sync, dat_q, dir_q, opt_q;
  logic [W-1:0] oe_c, drv_c, pu_c, ana_c, irq_c;

  gpio_sync #(.W(W), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .async_in(pin_in), .sync_out(pin_sync)
  );

  gpio_regfile #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .pin_sync(pin_sync), .rd_data(rd_data),
    .dat_q(dat_q), .dir_q(dir_q), .opt_q(opt_q)
  );

  for (genvar i = 0; i < W; i++) begin : g_cell
    gpio_bit_cell u_cell (
      .dir(dir_q[i]), .opt(opt_q[i]), .dat(dat_q[i]), .lvl(pin_sync[i]),
      .oe(oe_c[i]), .drv(drv_c[i]), .pu(pu_c[i]), .ana(ana_c[i]),
      .irq_term(irq_c[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_oe       <= '0;
      pin_out      <= '0;
      pin_pu       <= '1;
      ana_sel      <= '0;
      irq_n        <= 1'b1;
      ana_conflict <= 1'b0;
    end else begin
      pin_oe       <= oe_c;
      pin_out      <= drv_c;
      pin_pu       <= pu_c;
      ana_sel      <= ana_c;
      irq_n        <= &irq_c;
      ana_conflict <= |(ana_c & (ana_c - 1'b1));
    end
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   addr,
  input logic         wr_en,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] rd_data,
  input logic [W-1:0] pin_oe,
  input logic [W-1:0] pin_out,
  input logic [W-1:0] pin_pu,
  input logic [W-1:0] ana_sel,
  input logic         ana_conflict
);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pin_pu == '1 && pin_oe == '0 && ana_sel == '0));

  p_no_pu_on_drive_r2: assert property (@(posedge clk) disable iff (rst)
    (pin_pu & pin_oe) == '0);

  p_analog_isolated_r3: assert property (@(posedge clk) disable iff (rst)
    (ana_sel & (pin_pu | pin_oe)) == '0);

  p_level_needs_oe_r5: assert property (@(posedge clk) disable iff (rst)
    (pin_out & ~pin_oe) == '0);

  p_dir_readback_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 2'd1) |=> (addr != 2'd1 || rd_data == $past(wr_data)));

  p_conflict_set_r10: assert property (@(posedge clk) disable iff (rst)
    ($countones(ana_sel) > 1) |-> ana_conflict);

  p_conflict_clr_r10: assert property (@(posedge clk) disable iff (rst)
    !ana_conflict |-> $onehot0(ana_sel));
endmodule

bind gpio_port gpio_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu),
  .ana_sel(ana_sel), .ana_conflict(ana_conflict)
);

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst = 1'b1;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0, pin_in = '0;
  logic [7:0] rd_data, pin_oe, pin_out, pin_pu, ana_sel;
  logic       irq_n, ana_conflict;

  gpio_port #(.W(8)) dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out),
    .pin_pu(pin_pu), .ana_sel(ana_sel), .irq_n(irq_n), .ana_conflict(ana_conflict)
  );

  int total = 0, bad = 0;
  bit started = 0, done = 0;

  // behavioural reference state
  logic [7:0] m_dat, m_dir, m_opt, s1, s2;
  logic [7:0] e_oe, e_out, e_pu, e_ana;
  logic       e_irq, e_conf;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_dat = 0; m_dir = 0; m_opt = 0; s1 = 0; s2 = 0;
      e_oe = 0; e_out = 0; e_pu = 8'hFF; e_ana = 0; e_irq = 1; e_conf = 0;
    end else begin
      int n_ana;
      e_oe = 0; e_out = 0; e_pu = 0; e_ana = 0; e_irq = 1; n_ana = 0;
      for (int i = 0; i < 8; i++) begin
        if (m_dir[i]) begin
          if (m_opt[i]) begin e_oe[i] = 1; e_out[i] = m_dat[i]; end
          else e_oe[i] = !m_dat[i];
        end else if (!m_opt[i]) begin
          e_pu[i] = !m_dat[i];
        end else if (!m_dat[i]) begin
          e_pu[i] = 1;
          if (!s2[i]) e_irq = 0;
        end else begin
          e_ana[i] = 1; n_ana++;
        end
      end
      e_conf = (n_ana >= 2);
      if (wr_en) begin
        if (addr == 0) m_dat = wr_data;
        else if (addr == 1) m_dir = wr_data;
        else if (addr == 2) m_opt = wr_data;
      end
      s2 = s1; s1 = pin_in;
    end
    started = 1;
  end

  always @(negedge clk) begin
    if (started) begin
      logic [7:0] e_rd;
      case (addr)
        2'd0: e_rd = (m_dir & m_dat) | (~m_dir & s2);
        2'd1: e_rd = m_dir;
        2'd2: e_rd = m_opt;
        default: e_rd = 0;
      endcase
      check(addr == 0 ? "R6 rd_data" : "R7 rd_data", rd_data, e_rd);
      check("R2/R4/R5/R11 pin_oe", pin_oe, e_oe);
      check("R4/R5 pin_out", pin_out, e_out);
      check("R2/R3 pin_pu", pin_pu, e_pu);
      check("R3 ana_sel", ana_sel, e_ana);
      check("R9 irq_n", {7'd0, irq_n}, {7'd0, e_irq});
      check("R10 ana_conflict", {7'd0, ana_conflict}, {7'd0, e_conf});
    end
  end

  task automatic step(input logic [1:0] a, input logic we, input logic [7:0] wd, input logic [7:0] p);
    @(posedge clk); #1;
    addr = a; wr_en = we; wr_data = wd; pin_in = p;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R1: explicit reset state
    check("R1 pin_pu", pin_pu, 8'hFF);
    check("R1 pin_oe", pin_oe, 8'h00);
    check("R1 irq_n", {7'd0, irq_n}, 8'h01);
    step(2'd1, 0, 0, 0);
    @(negedge clk) check("R1 dir reset", rd_data, 8'h00);

    // R2 / R6: inputs with and without pull-up, live pin reads
    step(2'd0, 1, 8'h0F, 8'h00);
    step(2'd0, 0, 0, 8'h5A);
    step(2'd0, 0, 0, 8'h5A);
    step(2'd0, 0, 0, 8'h3C);
    repeat (3) step(2'd0, 0, 0, 8'h3C);

    // R4 / R5 / R8: mixed outputs, data write also lands while inputs
    step(2'd1, 1, 8'hF0, 8'hFF);
    step(2'd2, 1, 8'hC0, 8'h00);
    step(2'd0, 1, 8'hA5, 8'h00);
    repeat (3) step(2'd0, 0, 0, 8'h0F);

    // R9: interrupt pins on bits 2,3
    step(2'd1, 1, 8'h00, 8'hFF);
    step(2'd2, 1, 8'h0C, 8'hFF);
    step(2'd0, 1, 8'h00, 8'hFF);
    repeat (3) step(2'd0, 0, 0, 8'hFB);
    repeat (3) step(2'd0, 0, 0, 8'hFF);
    repeat (3) step(2'd0, 0, 0, 8'hF7);

    // R3 / R10: two analog pins, then one
    step(2'd2, 1, 8'h30, 8'h00);
    step(2'd0, 1, 8'h30, 8'h00);
    repeat (2) step(2'd0, 0, 0, 8'h00);
    step(2'd0, 1, 8'h10, 8'h00);
    repeat (2) step(2'd0, 0, 0, 8'h00);

    // R7: unused address ignored and reads zero
    step(2'd3, 1, 8'hFF, 8'h00);
    step(2'd3, 0, 0, 8'h00);
    step(2'd1, 0, 0, 8'h00);
    step(2'd2, 0, 0, 8'h00);
    step(2'd0, 0, 0, 8'h00);

    // mixed random traffic, biased toward analog settings
    for (int k = 0; k < 600; k++) begin
      logic [7:0] wd;
      wd = 8'($urandom);
      if (k % 5 == 0) wd = wd | 8'h50;
      step(2'($urandom), 1'($urandom), wd, 8'($urandom));
    end
    step(2'd0, 0, 0, 0);
    repeat (2) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule